// File: doc/BRIEF.md
# DDR SDRAM Mode Register Command Decoder

This block watches the command strobes of a DDR SDRAM device from the memory side and picks out the commands that program the mode registers. When such a command is legal, it captures the address word: into the base mode register (decoded into CAS latency, burst type, burst length and operating mode) or into a raw extended-mode word. A request to reset the DLL comes out as a single-cycle pulse and is not kept as a level.

The block also checks three protocol rules. All banks must be idle. Clock enable must have been high in the cycle before the command. No command other than NOP or deselect may arrive while the register is being written. Each broken rule raises its own one-cycle violation flag, and the register is left unchanged. CAS latency is reported in half-cycle units, so fractional latencies are exact. A single flag marks any reserved encoding held in the base register.

Top module: `mrs_decoder`

## Requirements
- R1: A command is a mode-register write when `cs_n_i`, `ras_n_i`, `cas_n_i` and `we_n_i` are all low at a clock edge. `ba_i[0]`=0 targets the base register. `ba_i[0]`=1 targets the extended register, which stores the whole address word in `ext_word_o` and sets `ext_valid_o`, without touching the base fields.
- R2: If any bit of `bank_idle_i` is low when the write command is sampled, `viol_bank_o` is high for the following cycle and no register changes.
- R3: If `cke_i` was low at the clock edge before the write command (or that edge was in reset), `viol_cke_o` is high for the following cycle and no register changes.
- R4: After an accepted write, the next `BUSY_CYCLES-1` cycles form a busy window (one cycle by default). In that window, any command that is neither deselect (`cs_n_i`=1) nor NOP (`ras_n_i`,`cas_n_i`,`we_n_i`=1) raises `viol_busy_o` for one cycle. A write command in the window is not applied.
- R5: The decoded fields keep their values across all other commands until a later accepted base write.
- R6: Address bits 6:4 give CAS latency in half cycles on `cas_half_o`: 101 gives 3 (1.5), 010 gives 4 (2), 110 gives 5 (2.5) and 011 gives 6 (3). Any other code gives 0 and sets `rsvd_code_o`.
- R7: Address bit 3 drives `burst_interleave_o`: 0 means sequential and 1 means interleave.
- R8: Address bits 2:0 give `burst_len_o`: 001 gives 2, 010 gives 4 and 011 gives 8. Any other code gives 0 and sets `rsvd_code_o`.
- R9: Address bits 12:9 and bit 7 must all be zero. When they are, bit 8 set on an accepted base write produces a one-cycle `dll_reset_pulse_o`. Any other combination gives no pulse and sets `rsvd_code_o`. A nonzero `ba_i[1]` on a base write also sets `rsvd_code_o`.
- R10: Reset (synchronous, active high) clears every field, flag and pulse. `cfg_valid_o` rises only on the first accepted base write, and never on an extended write.
- R11: All outputs are registered. Results of a command sampled at edge k are visible from edge k until edge k+1. The violation flags and the DLL pulse last one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cke_i | input | 1 | Clock enable |
| cs_n_i | input | 1 | Chip select, active low |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Write enable, active low |
| ba_i | input | BA_W | Bank address |
| addr_i | input | ADDR_W | Address bus |
| bank_idle_i | input | NUM_BANKS | Per-bank idle status |
| cfg_valid_o | output | 1 | Base register programmed |
| cas_half_o | output | 3 | CAS latency in half cycles, 0 if reserved |
| burst_interleave_o | output | 1 | Burst type, 1 = interleave |
| burst_len_o | output | 4 | Burst length, 0 if reserved |
| rsvd_code_o | output | 1 | Base register holds a reserved encoding |
| dll_reset_pulse_o | output | 1 | One-cycle DLL reset request |
| ext_valid_o | output | 1 | Extended register programmed |
| ext_word_o | output | ADDR_W | Extended register contents |
| viol_bank_o | output | 1 | Write attempted with a bank open |
| viol_cke_o | output | 1 | Write attempted without prior clock enable |
| viol_busy_o | output | 1 | Command inside the busy window |

## Verification
The bench uses the default parameters: four banks, a 13-bit address, a 2-bit bank address and a two-cycle write window. The 13-bit address lets the bench set the test-mode bits 12:9 and bit 10, so the reserved operating-mode path can be driven. Four banks let one bank be open while the others are idle. The two-cycle window leaves exactly one follow-up cycle, where the bench puts an active command, a second write and a deselect in turn. A reference model in the bench tracks the previous clock enable and the window counter, so every cycle's outputs are predicted from the requirements alone.

// File: rtl/mrs_pkg.sv
package mrs_pkg;

    typedef enum logic [1:0] {
        CMD_IDLE  = 2'd0,
        CMD_MRS   = 2'd1,
        CMD_OTHER = 2'd2
    } cmd_kind_e;

    typedef struct packed {
        logic [2:0] cas_half;
        logic       interleave;
        logic [3:0] burst_len;
        logic       rsvd;
    } mode_fields_t;

    localparam mode_fields_t FIELDS_BLANK = '{cas_half: 3'd0, interleave: 1'b0,
                                              burst_len: 4'd0, rsvd: 1'b0};

    function automatic logic [2:0] cas_half_of(input logic [2:0] code);
        logic [2:0] r;
        case (code)
            3'b101:  r = 3'd3;
            3'b010:  r = 3'd4;
            3'b110:  r = 3'd5;
            3'b011:  r = 3'd6;
            default: r = 3'd0;
        endcase
        return r;
    endfunction

    function automatic logic [3:0] burst_len_of(input logic [2:0] code);
        logic [3:0] r;
        case (code)
            3'b001:  r = 4'd2;
            3'b010:  r = 4'd4;
            3'b011:  r = 4'd8;
            default: r = 4'd0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/mrs_cmd_decode.sv
module mrs_cmd_decode
    import mrs_pkg::*;
(
    input  logic      cs_n_i,
    input  logic      ras_n_i,
    input  logic      cas_n_i,
    input  logic      we_n_i,
    output cmd_kind_e kind_o
);
    always_comb begin
        if (cs_n_i || (ras_n_i && cas_n_i && we_n_i))
            kind_o = CMD_IDLE;
        else if (!ras_n_i && !cas_n_i && !we_n_i)
            kind_o = CMD_MRS;
        else
            kind_o = CMD_OTHER;
    end
endmodule

// File: rtl/mrs_guard.sv
module mrs_guard
    import mrs_pkg::*;
#(
    parameter int NUM_BANKS   = 4,
    parameter int BUSY_CYCLES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cke_i,
    input  cmd_kind_e            kind_i,
    input  logic [NUM_BANKS-1:0] bank_idle_i,
    output logic                 accept_o,
    output logic                 viol_bank_o,
    output logic                 viol_cke_o,
    output logic                 viol_busy_o
);
    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
    localparam logic [CNT_W-1:0] HOLD = CNT_W'(BUSY_CYCLES - 1);

    logic             cke_prev_q;
    logic [CNT_W-1:0] busy_q;
    logic             all_idle;
    logic             is_mrs;
    logic             in_window;

    always_comb begin
        all_idle  = &bank_idle_i;
        is_mrs    = (kind_i == CMD_MRS);
        in_window = (busy_q != '0);
        accept_o  = is_mrs && all_idle && cke_prev_q && !in_window;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cke_prev_q  <= 1'b0;
            busy_q      <= '0;
            viol_bank_o <= 1'b0;
            viol_cke_o  <= 1'b0;
            viol_busy_o <= 1'b0;
        end else begin
            cke_prev_q  <= cke_i;
            viol_bank_o <= is_mrs && !all_idle;
            viol_cke_o  <= is_mrs && !cke_prev_q;
            viol_busy_o <= in_window && (kind_i != CMD_IDLE);
            if (accept_o)
                busy_q <= HOLD;
            else if (in_window)
                busy_q <= busy_q - 1'b1;
        end
    end
endmodule

// File: rtl/mrs_field_reg.sv
module mrs_field_reg
    import mrs_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int BA_W   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept_i,
    input  logic [BA_W-1:0]   ba_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              cfg_valid_o,
    output mode_fields_t      fields_o,
    output logic              dll_pulse_o,
    output logic              ext_valid_o,
    output logic [ADDR_W-1:0] ext_word_o
);
    localparam int OP_HI = 9;

    logic         upper_clear;
    logic         ba_upper_clear;
    logic         op_ok;
    logic         dll_req;
    mode_fields_t decoded;

    generate
        if (ADDR_W > OP_HI) begin : g_upper
            assign upper_clear = (addr_i[ADDR_W-1:OP_HI] == '0);
        end else begin : g_noupper
            assign upper_clear = 1'b1;
        end
        if (BA_W > 1) begin : g_ba
            assign ba_upper_clear = (ba_i[BA_W-1:1] == '0);
        end else begin : g_noba
            assign ba_upper_clear = 1'b1;
        end
    endgenerate

    always_comb begin
        op_ok              = upper_clear && !addr_i[7];
        dll_req            = op_ok && addr_i[8];
        decoded.cas_half   = cas_half_of(addr_i[6:4]);
        decoded.interleave = addr_i[3];
        decoded.burst_len  = burst_len_of(addr_i[2:0]);
        decoded.rsvd       = (decoded.cas_half == 3'd0) || (decoded.burst_len == 4'd0)
                             || !op_ok || !ba_upper_clear;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_valid_o <= 1'b0;
            fields_o    <= FIELDS_BLANK;
            dll_pulse_o <= 1'b0;
            ext_valid_o <= 1'b0;
            ext_word_o  <= '0;
        end else begin
            dll_pulse_o <= accept_i && !ba_i[0] && dll_req;
            if (accept_i && !ba_i[0]) begin
                cfg_valid_o <= 1'b1;
                fields_o    <= decoded;
            end
            if (accept_i && ba_i[0]) begin
                ext_valid_o <= 1'b1;
                ext_word_o  <= addr_i;
            end
        end
    end
endmodule

// File: rtl/mrs_decoder.sv
module mrs_decoder
    import mrs_pkg::*;
#(
    parameter int ADDR_W      = 13,
    parameter int BA_W        = 2,
    parameter int NUM_BANKS   = 4,
    parameter int BUSY_CYCLES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cke_i,
    input  logic                 cs_n_i,
    input  logic                 ras_n_i,
    input  logic                 cas_n_i,
    input  logic                 we_n_i,
    input  logic [BA_W-1:0]      ba_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [NUM_BANKS-1:0] bank_idle_i,
    output logic                 cfg_valid_o,
    output logic [2:0]           cas_half_o,
    output logic                 burst_interleave_o,
    output logic [3:0]           burst_len_o,
    output logic                 rsvd_code_o,
    output logic                 dll_reset_pulse_o,
    output logic                 ext_valid_o,
    output logic [ADDR_W-1:0]    ext_word_o,
    output logic                 viol_bank_o,
    output logic                 viol_cke_o,
    output logic                 viol_busy_o
);
    cmd_kind_e    kind_w;
    logic         accept_w;
    mode_fields_t fields_w;

    mrs_cmd_decode u_cmd (
        .cs_n_i  (cs_n_i),
        .ras_n_i (ras_n_i),
        .cas_n_i (cas_n_i),
        .we_n_i  (we_n_i),
        .kind_o  (kind_w)
    );

    mrs_guard #(.NUM_BANKS(NUM_BANKS), .BUSY_CYCLES(BUSY_CYCLES)) u_guard (
        .clk         (clk),
        .rst         (rst),
        .cke_i       (cke_i),
        .kind_i      (kind_w),
        .bank_idle_i (bank_idle_i),
        .accept_o    (accept_w),
        .viol_bank_o (viol_bank_o),
        .viol_cke_o  (viol_cke_o),
        .viol_busy_o (viol_busy_o)
    );

    mrs_field_reg #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_fields (
        .clk         (clk),
        .rst         (rst),
        .accept_i    (accept_w),
        .ba_i        (ba_i),
        .addr_i      (addr_i),
        .cfg_valid_o (cfg_valid_o),
        .fields_o    (fields_w),
        .dll_pulse_o (dll_reset_pulse_o),
        .ext_valid_o (ext_valid_o),
        .ext_word_o  (ext_word_o)
    );

    assign cas_half_o         = fields_w.cas_half;
    assign burst_interleave_o = fields_w.interleave;
    assign burst_len_o        = fields_w.burst_len;
    assign rsvd_code_o        = fields_w.rsvd;
endmodule

// File: rtl/mrs_decoder_chk.sv
module mrs_decoder_chk (
    input logic       clk,
    input logic       rst,
    input logic       accept,
    input logic       cfg_valid_o,
    input logic [2:0] cas_half_o,
    input logic [3:0] burst_len_o,
    input logic       dll_reset_pulse_o,
    input logic       ext_valid_o,
    input logic       viol_bank_o,
    input logic       viol_cke_o,
    input logic       viol_busy_o
);
    assert_bank_blocks_R2: assert property (@(posedge clk) disable iff (rst)
        viol_bank_o |-> ($stable(cas_half_o) && $stable(burst_len_o)
                         && $stable(cfg_valid_o) && $stable(ext_valid_o)));

    assert_cke_blocks_R3: assert property (@(posedge clk) disable iff (rst)
        viol_cke_o |-> ($stable(cas_half_o) && $stable(burst_len_o)
                        && $stable(cfg_valid_o) && $stable(ext_valid_o)));

    assert_no_back_to_back_R4: assert property (@(posedge clk) disable iff (rst)
        accept |=> !accept);

    assert_cas_legal_R6: assert property (@(posedge clk) disable iff (rst)
        cas_half_o inside {3'd0, 3'd3, 3'd4, 3'd5, 3'd6});

    assert_len_legal_R8: assert property (@(posedge clk) disable iff (rst)
        burst_len_o inside {4'd0, 4'd2, 4'd4, 4'd8});

    assert_dll_single_R9: assert property (@(posedge clk) disable iff (rst)
        dll_reset_pulse_o |=> !dll_reset_pulse_o);

    assert_dll_after_write_R9: assert property (@(posedge clk) disable iff (rst)
        dll_reset_pulse_o |-> cfg_valid_o);

    assert_blank_until_valid_R10: assert property (@(posedge clk) disable iff (rst)
        !cfg_valid_o |-> (cas_half_o == 3'd0 && burst_len_o == 4'd0));

    assert_valid_clean_rise_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_valid_o) |-> !(viol_bank_o || viol_cke_o || viol_busy_o));
endmodule

bind mrs_decoder mrs_decoder_chk u_chk (
    .clk               (clk),
    .rst               (rst),
    .accept            (accept_w),
    .cfg_valid_o       (cfg_valid_o),
    .cas_half_o        (cas_half_o),
    .burst_len_o       (burst_len_o),
    .dll_reset_pulse_o (dll_reset_pulse_o),
    .ext_valid_o       (ext_valid_o),
    .viol_bank_o       (viol_bank_o),
    .viol_cke_o        (viol_cke_o),
    .viol_busy_o       (viol_busy_o)
);

// File: tb/mrs_decoder_bench.sv
module mrs_decoder_bench;

    typedef struct packed {
        logic        valid;
        logic [2:0]  cas;
        logic        il;
        logic [3:0]  bl;
        logic        rsvd;
        logic        dll;
        logic        xv;
        logic [12:0] xw;
        logic        vb;
        logic        vc;
        logic        vy;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst;
    logic        cke;
    logic        cs_n, ras_n, cas_n, we_n;
    logic [1:0]  ba;
    logic [12:0] addr;
    logic [3:0]  idle;

    logic        cfg_valid, burst_il, rsvd, dll, xv, vb, vc, vy;
    logic [2:0]  cas_half;
    logic [3:0]  blen;
    logic [12:0] xw;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    exp_t  exp_q[$];
    string tag_q[$];

    // reference state
    exp_t m;
    logic m_ckeprev;
    int   m_busy;

    always #5 clk = ~clk;

    mrs_decoder u_mrs_decoder (
        .clk (clk), .rst (rst), .cke_i (cke),
        .cs_n_i (cs_n), .ras_n_i (ras_n), .cas_n_i (cas_n), .we_n_i (we_n),
        .ba_i (ba), .addr_i (addr), .bank_idle_i (idle),
        .cfg_valid_o (cfg_valid), .cas_half_o (cas_half),
        .burst_interleave_o (burst_il), .burst_len_o (blen),
        .rsvd_code_o (rsvd), .dll_reset_pulse_o (dll),
        .ext_valid_o (xv), .ext_word_o (xw),
        .viol_bank_o (vb), .viol_cke_o (vc), .viol_busy_o (vy)
    );

    function automatic logic [12:0] mk(input logic [3:0] hi, input logic b8, input logic b7,
                                       input logic [2:0] cl, input logic bt, input logic [2:0] bl);
        return {hi, b8, b7, cl, bt, bl};
    endfunction

    // Driver: applies one cycle of stimulus and pushes the predicted outputs.
    task automatic drive(input logic r, input logic k, input logic [3:0] cmd,
                         input logic [1:0] b, input logic [12:0] a,
                         input logic [3:0] id, input string tag);
        logic mrs, quiet, acc, opok;
        @(negedge clk);
        rst = r; cke = k; {cs_n, ras_n, cas_n, we_n} = cmd; ba = b; addr = a; idle = id;
        mrs   = (cmd == 4'b0000);
        quiet = cmd[3] || (cmd[2:0] == 3'b111);
        if (r) begin
            m = '0; m_ckeprev = 1'b0; m_busy = 0;
        end else begin
            m.vb  = mrs && (id != 4'hF);
            m.vc  = mrs && !m_ckeprev;
            m.vy  = (m_busy != 0) && !quiet;
            acc   = mrs && (id == 4'hF) && m_ckeprev && (m_busy == 0);
            m.dll = 1'b0;
            if (acc && !b[0]) begin
                opok    = (a[12:9] == 4'd0) && !a[7];
                m.valid = 1'b1;
                case (a[6:4])
                    3'b101: m.cas = 3'd3;  3'b010: m.cas = 3'd4;
                    3'b110: m.cas = 3'd5;  3'b011: m.cas = 3'd6;
                    default: m.cas = 3'd0;
                endcase
                case (a[2:0])
                    3'b001: m.bl = 4'd2;  3'b010: m.bl = 4'd4;  3'b011: m.bl = 4'd8;
                    default: m.bl = 4'd0;
                endcase
                m.il   = a[3];
                m.dll  = opok && a[8];
                m.rsvd = (m.cas == 3'd0) || (m.bl == 4'd0) || !opok || b[1];
            end
            if (acc && b[0]) begin
                m.xv = 1'b1; m.xw = a;
            end
            if (acc) m_busy = 1;
            else if (m_busy != 0) m_busy = m_busy - 1;
            m_ckeprev = k;
        end
        exp_q.push_back(m);
        tag_q.push_back(tag);
    endtask

    // Monitor: compares after each edge has settled.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() != 0) begin
                exp_t  e;
                exp_t  g;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                g = '{valid: cfg_valid, cas: cas_half, il: burst_il, bl: blen, rsvd: rsvd,
                      dll: dll, xv: xv, xw: xw, vb: vb, vc: vc, vy: vy};
                checks++;
                if (g !== e) begin
                    fails++;
                    $display("FAIL %s got valid=%b cas=%0d il=%b bl=%0d rsvd=%b dll=%b xv=%b xw=%h vb=%b vc=%b vy=%b exp valid=%b cas=%0d il=%b bl=%0d rsvd=%b dll=%b xv=%b xw=%h vb=%b vc=%b vy=%b",
                             t, g.valid, g.cas, g.il, g.bl, g.rsvd, g.dll, g.xv, g.xw, g.vb, g.vc, g.vy,
                             e.valid, e.cas, e.il, e.bl, e.rsvd, e.dll, e.xv, e.xw, e.vb, e.vc, e.vy);
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog expired got running exp finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    localparam logic [3:0] NOP  = 4'b0111;
    localparam logic [3:0] DES  = 4'b1111;
    localparam logic [3:0] MRS  = 4'b0000;
    localparam logic [3:0] ACT  = 4'b0011;
    localparam logic [3:0] RD   = 4'b0101;

    initial begin
        m = '0; m_ckeprev = 1'b0; m_busy = 0;
        rst = 1'b1; cke = 1'b0; {cs_n, ras_n, cas_n, we_n} = DES; ba = '0; addr = '0; idle = 4'hF;
        // R10 reset state
        drive(1, 0, DES, 2'b00, 13'h0, 4'hF, "R10 reset");
        drive(1, 1, DES, 2'b00, 13'h0, 4'hF, "R10 reset");
        drive(0, 0, NOP, 2'b00, 13'h0, 4'hF, "R10 idle after reset");
        // R3 clock enable low before command
        drive(0, 1, MRS, 2'b00, mk(4'd0,0,0,3'b010,0,3'b010), 4'hF, "R3 cke history");
        drive(0, 1, NOP, 2'b00, 13'h0, 4'hF, "R10 still blank");
        // R2 bank open
        drive(0, 1, MRS, 2'b00, mk(4'd0,0,0,3'b110,0,3'b010), 4'b1011, "R2 bank open");
        // R1 R6 R7 R8 R9 accepted base write with DLL reset
        drive(0, 1, MRS, 2'b00, mk(4'd0,1,0,3'b010,1,3'b011), 4'hF, "R1 R6 R7 R8 R9 base write");
        // R4 busy window with active command
        drive(0, 1, ACT, 2'b00, 13'h0, 4'hF, "R4 active in window");
        drive(0, 1, NOP, 2'b00, 13'h0, 4'hF, "R5 hold");
        drive(0, 1, MRS, 2'b00, mk(4'd0,0,0,3'b101,0,3'b001), 4'hF, "R6 R8 cl1.5 bl2");
        drive(0, 1, MRS, 2'b00, mk(4'd0,0,0,3'b011,1,3'b011), 4'hF, "R4 second write in window");
        drive(0, 1, NOP, 2'b00, 13'h0, 4'hF, "R5 hold");
        drive(0, 1, RD,  2'b00, 13'h1FFF, 4'hF, "R5 read ignored");
        drive(0, 1, ACT, 2'b00, 13'h0AAA, 4'h0, "R5 active ignored");
        // R1 extended register
        drive(0, 1, MRS, 2'b01, 13'h0002, 4'hF, "R1 extended write");
        drive(0, 1, DES, 2'b00, 13'h0, 4'hF, "R4 deselect in window");
        // R8 reserved burst length
        drive(0, 1, MRS, 2'b00, mk(4'd0,0,0,3'b011,0,3'b000), 4'hF, "R8 reserved length");
        drive(0, 1, NOP, 2'b00, 13'h0, 4'hF, "R4 nop in window");
        // R6 reserved CAS code
        drive(0, 1, MRS, 2'b00, mk(4'd0,0,0,3'b111,0,3'b010), 4'hF, "R6 reserved latency");
        drive(0, 1, NOP, 2'b00, 13'h0, 4'hF, "R11 flags drop");
        // R9 test mode bits with DLL bit: no pulse
        drive(0, 1, MRS, 2'b00, mk(4'b0010,1,0,3'b110,0,3'b010), 4'hF, "R9 test mode");
        drive(0, 1, NOP, 2'b00, 13'h0, 4'hF, "R11 idle");
        // R9 bank bit 1 set flags reserved
        drive(0, 1, MRS, 2'b10, mk(4'd0,0,0,3'b110,0,3'b010), 4'hF, "R9 upper bank bit");
        drive(0, 1, NOP, 2'b00, 13'h0, 4'hF, "R11 idle");
        // R6 clean write clears reserved flag
        drive(0, 1, MRS, 2'b00, mk(4'd0,0,0,3'b110,1,3'b010), 4'hF, "R6 R7 cl2.5 interleave");
        drive(0, 1, NOP, 2'b00, 13'h0, 4'hF, "R11 idle");
        // R3 cke drop then command
        drive(0, 0, NOP, 2'b00, 13'h0, 4'hF, "R3 cke low");
        drive(0, 1, MRS, 2'b00, mk(4'd0,0,0,3'b011,0,3'b001), 4'hF, "R3 after cke low");
        drive(0, 1, MRS, 2'b00, mk(4'd0,1,0,3'b011,0,3'b001), 4'hF, "R9 cl3 dll");
        drive(0, 1, NOP, 2'b00, 13'h0, 4'hF, "R9 pulse ends");
        drive(0, 1, NOP, 2'b00, 13'h0, 4'hF, "R5 hold");
        @(negedge clk);
        while (exp_q.size() != 0) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule